// File: doc/BRIEF.md
# Quad wiper register bank

This block keeps the tap-position state for four independent digitally controlled resistor ladders. Each ladder has 64 taps, so every channel carries one volatile 6-bit wiper register that alone decides which tap switch is closed. Every channel also has four stored preset registers. The presets are modelled here as ordinary flops that a reset sets to a factory value. The outputs are the four wiper values and, for each channel, a one-hot tap-enable vector that drives the switch array.

A host issues one command per cycle on a synchronous parallel interface: a strobe, an opcode, a channel number, a preset number and a data byte. The host can:
- write or read a wiper register directly;
- write or read a preset directly;
- copy a preset into the wiper register;
- copy the wiper register into a preset.

An active-low write-protect input blocks every change to a preset. A blocked write produces a one-cycle error pulse. Writes to the wiper register are never blocked. After reset the block spends one cycle recalling preset 0 into every wiper register. A busy flag is high during that cycle, and strobes given during it are ignored.

Top module: `quad_wiper_bank`

## Requirements
- R1: `tap_sel[c*6 +: 6]` equals the wiper register of channel c. `tap_en[c*64 +: 64]` has exactly one bit set, the bit at the index equal to that wiper value.
- R2: While `rst` is high, every wiper register is 0, tap 0 is enabled on every channel and `busy` is 1. `busy` stays 1 for exactly one cycle after `rst` falls. Reset sets every preset to `INIT_TAP` (default 32).
- R3: At the end of the busy cycle, every wiper register loads its channel's preset 0. `busy` is 0 from then on.
- R4: A strobe given while `busy` is high has no effect. It changes no wiper or preset and raises neither `rd_valid` nor `wp_err`.
- R5: Opcode 0 writes `cmd_wdata[5:0]` into the wiper register of channel `cmd_ch`, visible one clock after the strobe. Bits 7:6 are ignored, other channels are unchanged, and `wp_n` has no effect on this opcode.
- R6: Opcode 1 reads the wiper register. `rd_valid` pulses for exactly one cycle, one clock after the strobe, with `rd_data = {2'b00, value}`. `rd_valid` is 0 in every other cycle.
- R7: Opcode 2 writes `cmd_wdata[5:0]` into preset `cmd_reg` of channel `cmd_ch` when `wp_n` is 1. Opcode 3 reads that preset, with the timing of R6.
- R8: Opcode 4 copies preset `cmd_reg` into the wiper register. Opcode 5 copies the wiper register into preset `cmd_reg` when `wp_n` is 1. Both complete one clock after the strobe.
- R9: When `wp_n` is 0, opcodes 2 and 5 leave the preset unchanged and `wp_err` pulses for one cycle, one clock after the strobe. `wp_err` is 0 otherwise.
- R10: Opcodes 6 and 7 are no-ops. They change no state and raise neither `rd_valid` nor `wp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode (0 write wiper, 1 read wiper, 2 write preset, 3 read preset, 4 preset to wiper, 5 wiper to preset) |
| cmd_ch | input | 2 | Channel number |
| cmd_reg | input | 2 | Preset number |
| cmd_wdata | input | 8 | Write data; bits 5:0 used |
| wp_n | input | 1 | Write enable for presets; low blocks preset changes |
| busy | output | 1 | High during reset and the recall cycle |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Read data, zero-extended |
| wp_err | output | 1 | Pulse on a blocked preset write |
| tap_sel | output | 24 | Four packed 6-bit wiper values |
| tap_en | output | 256 | Four packed one-hot 64-bit tap enables |

## Verification
The assertions assume that `rst` is held high from time zero for at least one clock. They also assume that every command input is driven to a known value on each clock edge, so that a strobe, its opcode and its channel are sampled together. The bench drives all command inputs on the falling edge and keeps `wp_n` stable for the whole of a command. Random opcodes cover all eight codes, including the two no-ops. Strobes are given only at points where the expected effect on the four wiper registers and sixteen presets can be computed.

// File: rtl/quad_wiper_bank.sv
module quad_wiper_bank #(
  parameter int NUM_CH   = 4,
  parameter int NUM_PRE  = 4,
  parameter int TAP_W    = 6,
  parameter int DATA_W   = 8,
  parameter int INIT_TAP = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cmd_valid,
  input  logic [2:0]                       cmd_op,
  input  logic [$clog2(NUM_CH)-1:0]        cmd_ch,
  input  logic [$clog2(NUM_PRE)-1:0]       cmd_reg,
  input  logic [DATA_W-1:0]                cmd_wdata,
  input  logic                             wp_n,
  output logic                             busy,
  output logic                             rd_valid,
  output logic [DATA_W-1:0]                rd_data,
  output logic                             wp_err,
  output logic [NUM_CH*TAP_W-1:0]          tap_sel,
  output logic [NUM_CH*(1<<TAP_W)-1:0]     tap_en
);
  localparam int NUM_TAPS = 1 << TAP_W;

  localparam logic [2:0] OP_WR_WIP = 3'd0;
  localparam logic [2:0] OP_RD_WIP = 3'd1;
  localparam logic [2:0] OP_WR_PRE = 3'd2;
  localparam logic [2:0] OP_RD_PRE = 3'd3;
  localparam logic [2:0] OP_P2W    = 3'd4;
  localparam logic [2:0] OP_W2P    = 3'd5;

  logic [TAP_W-1:0] wip [NUM_CH];
  logic [TAP_W-1:0] pre [NUM_CH][NUM_PRE];

  wire              go      = cmd_valid && !busy;
  wire [TAP_W-1:0]  wd      = cmd_wdata[TAP_W-1:0];
  wire              unused_hi = ^cmd_wdata[DATA_W-1:TAP_W];
  wire [TAP_W-1:0]  cur_w   = wip[cmd_ch];
  wire [TAP_W-1:0]  cur_p   = pre[cmd_ch][cmd_reg];
  wire              pre_wr  = go && (cmd_op == OP_WR_PRE || cmd_op == OP_W2P);
  wire              is_rd   = go && (cmd_op == OP_RD_WIP || cmd_op == OP_RD_PRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b1;
      rd_valid <= 1'b0;
      wp_err   <= 1'b0;
      rd_data  <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        wip[c] <= '0;
        for (int p = 0; p < NUM_PRE; p++) pre[c][p] <= TAP_W'(INIT_TAP);
      end
    end else begin
      busy     <= 1'b0;
      rd_valid <= is_rd;
      wp_err   <= pre_wr && !wp_n;
      if (busy)
        for (int c = 0; c < NUM_CH; c++) wip[c] <= pre[c][0];
      if (go) begin
        case (cmd_op)
          OP_WR_WIP: wip[cmd_ch] <= wd;
          OP_RD_WIP: rd_data <= DATA_W'(cur_w);
          OP_WR_PRE: if (wp_n) pre[cmd_ch][cmd_reg] <= wd;
          OP_RD_PRE: rd_data <= DATA_W'(cur_p);
          OP_P2W:    wip[cmd_ch] <= cur_p;
          OP_W2P:    if (wp_n) pre[cmd_ch][cmd_reg] <= cur_w;
          default: ;
        endcase
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_out
    assign tap_sel[c*TAP_W +: TAP_W]      = wip[c];
    assign tap_en[c*NUM_TAPS +: NUM_TAPS] = NUM_TAPS'(1) << wip[c];
  end
endmodule

// File: rtl/quad_wiper_bank_chk.sv
module quad_wiper_bank_chk #(
  parameter int NUM_CH  = 4,
  parameter int TAP_W   = 6,
  parameter int DATA_W  = 8
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             busy,
  input logic                             cmd_valid,
  input logic [2:0]                       cmd_op,
  input logic [$clog2(NUM_CH)-1:0]        cmd_ch,
  input logic [TAP_W-1:0]                 wd,
  input logic                             wp_n,
  input logic                             rd_valid,
  input logic [DATA_W-TAP_W-1:0]          rd_hi,
  input logic                             wp_err,
  input logic [NUM_CH*TAP_W-1:0]          tap_sel,
  input logic [NUM_CH*(1<<TAP_W)-1:0]     tap_en
);
  localparam int NT = 1 << TAP_W;

  logic [$clog2(NUM_CH)-1:0] ch_q;
  logic [TAP_W-1:0]          wd_q;
  always_ff @(posedge clk) begin
    ch_q <= cmd_ch;
    wd_q <= wd;
  end

  wire go = cmd_valid && !busy;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_oh
    // R1
    tap_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(tap_en[c*NT +: NT]) == 1 &&
      tap_en[c*NT + int'(tap_sel[c*TAP_W +: TAP_W])]);
  end

  // R2
  busy_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> busy);

  // R3
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  // R4
  busy_ignores_chk: assert property (@(posedge clk) disable iff (rst)
    busy && cmd_valid |=> !rd_valid && !wp_err);

  // R5
  wiper_write_chk: assert property (@(posedge clk) disable iff (rst)
    go && cmd_op == 3'd0 |=> tap_sel[ch_q*TAP_W +: TAP_W] == wd_q);

  // R6
  read_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    go && (cmd_op == 3'd1 || cmd_op == 3'd3) |=> rd_valid);

  // R6
  read_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_hi == '0);

  // R9
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    go && !wp_n && (cmd_op == 3'd2 || cmd_op == 3'd5) |=> wp_err);

  // R10
  noop_chk: assert property (@(posedge clk) disable iff (rst)
    go && cmd_op[2:1] == 2'b11 |=> !rd_valid && !wp_err && $stable(tap_sel));
endmodule

bind quad_wiper_bank quad_wiper_bank_chk #(
  .NUM_CH(NUM_CH), .TAP_W(TAP_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_ch(cmd_ch), .wd(cmd_wdata[TAP_W-1:0]), .wp_n(wp_n), .rd_valid(rd_valid),
  .rd_hi(rd_data[DATA_W-1:TAP_W]), .wp_err(wp_err), .tap_sel(tap_sel), .tap_en(tap_en)
);

// File: tb/tb_quad_wiper_bank.sv
module tb_quad_wiper_bank;
  localparam int CLK_PERIOD = 10;
  localparam int INIT = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_op = '0;
  logic [1:0]   cmd_ch = '0;
  logic [1:0]   cmd_reg = '0;
  logic [7:0]   cmd_wdata = '0;
  logic         wp_n = 1'b1;
  logic         busy, rd_valid, wp_err;
  logic [7:0]   rd_data;
  logic [23:0]  tap_sel;
  logic [255:0] tap_en;

  int errors = 0;
  int checks = 0;
  int m_w [4];
  int m_p [4][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_wiper_bank dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ch(cmd_ch),
    .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .wp_n(wp_n), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .wp_err(wp_err),
    .tap_sel(tap_sel), .tap_en(tap_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input int op);
    case (op)
      0: return "R5";
      1: return "R6";
      2, 3: return "R7";
      4, 5: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check_taps();
    for (int c = 0; c < 4; c++) begin
      chk("R1 tap_sel", int'(tap_sel[c*6 +: 6]), m_w[c]);
      chk("R1 tap_en one-hot", int'(tap_en[c*64 +: 64] == (64'd1 << m_w[c])), 1);
    end
  endtask

  task automatic issue(input int op, input int ch, input int rg, input int d, input bit wp);
    int  exp_rd = 0;
    bit  exp_rv = 0;
    bit  exp_err = 0;
    @(negedge clk);
    chk("R6 rd_valid idle", int'(rd_valid), 0);
    chk("R9 wp_err idle", int'(wp_err), 0);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_ch = 2'(ch); cmd_reg = 2'(rg);
    cmd_wdata = 8'(d); wp_n = wp;
    case (op)
      0: m_w[ch] = d & 63;
      1: begin exp_rv = 1; exp_rd = m_w[ch]; end
      2: if (wp) m_p[ch][rg] = d & 63; else exp_err = 1;
      3: begin exp_rv = 1; exp_rd = m_p[ch][rg]; end
      4: m_w[ch] = m_p[ch][rg];
      5: if (wp) m_p[ch][rg] = m_w[ch]; else exp_err = 1;
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({op_tag(op), " rd_valid"}, int'(rd_valid), int'(exp_rv));
    if (exp_rv) chk({op_tag(op), " rd_data"}, int'(rd_data), exp_rd);
    chk("R9 wp_err", int'(wp_err), int'(exp_err));
    check_taps();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1357);
    for (int c = 0; c < 4; c++) begin
      m_w[c] = 0;
      for (int p = 0; p < 4; p++) m_p[c][p] = INIT;
    end
    repeat (3) @(negedge clk);
    chk("R2 busy in reset", int'(busy), 1);
    check_taps();
    rst = 1'b0;
    cmd_valid = 1'b1; cmd_op = 3'd0; cmd_ch = 2'd0; cmd_wdata = 8'd5;
    chk("R2 busy after reset release", int'(busy), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R3 busy cleared", int'(busy), 0);
    chk("R4 strobe while busy rd_valid", int'(rd_valid), 0);
    chk("R4 strobe while busy wp_err", int'(wp_err), 0);
    for (int c = 0; c < 4; c++) m_w[c] = INIT;
    check_taps();

    issue(0, 0, 0, 8'hFF, 1);
    issue(0, 1, 0, 8'h00, 0);
    issue(1, 1, 0, 0, 1);
    issue(1, 0, 0, 0, 0);
    issue(2, 2, 3, 8'h15, 1);
    issue(3, 2, 3, 0, 1);
    issue(2, 2, 3, 8'h2A, 0);
    issue(3, 2, 3, 0, 0);
    issue(5, 1, 0, 0, 0);
    issue(3, 1, 0, 0, 1);
    issue(4, 2, 3, 0, 0);
    issue(5, 2, 1, 0, 1);
    issue(3, 2, 1, 0, 1);
    issue(6, 3, 2, 8'h3F, 1);
    issue(7, 0, 1, 8'h01, 0);
    issue(3, 3, 2, 0, 1);

    for (int i = 0; i < 3000; i++)
      issue(int'($urandom_range(7)), int'($urandom_range(3)), int'($urandom_range(3)),
            int'($urandom_range(255)), ($urandom_range(3) != 0));
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 4; p++) issue(3, c, p, 0, 1);
    summary();
  end
endmodule